// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the timing signals for a parallel LCD panel: a divided pixel clock, line sync, frame sync, data-enable, a pixel request strobe for the upstream pixel FIFO, and an AC-bias toggle with a periodic interrupt strobe for passive panels. Every timing value comes from packed 32-bit configuration words supplied as static inputs. These words are the pixel clock divisor, the horizontal and vertical porches and sync widths, the active size, the polarity inverts, the AC-bias period and transition count, and the raster enable and panel-type bits.

Each line runs sync pulse, back porch, active pixels, front porch, counted in pixel periods. Each frame runs through the same four phases, counted in lines. The active width is programmed in multiples of 16 pixels. Software loads all configuration words first and then sets the raster enable. Clearing the enable returns the block to the start of a frame and parks every output at its idle level.

Top module: `lcd_raster_timer`

## Requirements
- R1: While reset is high or raster enable (`raster_word[0]`) is 0, at every clock edge the outputs take their idle levels: `pix_clk` equals the pixel-clock invert bit (`timing2[22]`), `hsync` equals the line invert bit (`timing2[21]`), `vsync` equals the frame invert bit (`timing2[20]`), and `de`, `pix_req`, `ac_bias` and `ac_irq` are 0.
- R2: The pixel period is D input clocks, where D is `ctrl_word[15:8]` and a value of 0 counts as 1. Within each period the raw pixel clock is 0 for the first floor(D/2) clocks and 1 for the rest. `pix_clk` is that raw value XOR `timing2[22]`.
- R3: A line starts with the sync phase. `hsync` is asserted (raw 1, output XOR `timing2[21]`) for `htiming[15:10]`+1 pixel periods.
- R4: After line sync come `htiming[31:24]`+1 back-porch pixels, then (`htiming[9:4]`+1)*16 active pixels, then `htiming[23:16]`+1 front-porch pixels.
- R5: A frame counts lines in the same order. `vsync` is asserted (raw 1, output XOR `timing2[20]`) for `vtiming[15:10]`+1 lines. It is followed by `vtiming[31:24]`+1 back-porch lines, `vtiming[9:0]`+1 active lines and `vtiming[23:16]`+1 front-porch lines.
- R6: `de` is 1 only when `raster_word[7]` (active-matrix mode) is 1 and both the pixel and the line are inside their active regions.
- R7: `pix_req` pulses for one clock in the last input clock of every pixel period that lies in the active area. This holds in either panel mode.
- R8: In passive mode (`raster_word[7]`=0), `ac_bias` toggles at the end of every (`timing2[15:8]`+1)-th line. In active-matrix mode it stays 0.
- R9: In passive mode, `ac_irq` pulses for one clock on every N-th `ac_bias` toggle, where N is `timing2[19:16]`. N=0 gives no pulses.
- R10: All outputs are registered. After the raster enable is set, the first clock edge already shows the first pixel period of a line, with `hsync` asserted.
- R11: Clearing the raster enable resets both counters. On re-enable the first edge shows the first line of a frame, with `vsync` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Divisor in [15:8] |
| raster_word | input | 32 | Enable [0], active-matrix mode [7] |
| htiming | input | 32 | Horizontal porches, sync width, width code |
| vtiming | input | 32 | Vertical porches, sync width, line count minus one |
| timing2 | input | 32 | Inverts [22:20], AC-bias count [19:16], period [15:8] |
| pix_clk | output | 1 | Pixel clock to panel |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Pixel request strobe to the FIFO |
| ac_bias | output | 1 | AC-bias drive |
| ac_irq | output | 1 | AC-bias transition-count strobe |

## Verification
The counters change on the edge that follows each state, and every output register samples the counters one edge later. As a result, the outputs seen after edge n describe the counter state reached after n-1 enabled edges. The line-end events that drive `ac_bias` and `ac_irq` show on the same edge n where n is a multiple of D times the line length. The bench numbers the edges from the moment enable is set and samples one time unit after each rising edge. From n alone it computes the divider phase, the pixel, the line and the toggle count by arithmetic, and compares every output at every edge.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  localparam int LEN_W = 12;

  // Layout shared by the horizontal and vertical timing words
  typedef struct packed {
    logic [7:0] back;
    logic [7:0] front;
    logic [5:0] sync;
    logic [9:0] size;
  } axis_word_t;

  typedef struct packed {
    logic [5:0] unused_hi;
    logic [1:0] unused_sync;
    logic       unused_b23;
    logic       inv_pix;
    logic       inv_line;
    logic       inv_frame;
    logic [3:0] acb_count;
    logic [7:0] acb_period;
    logic [7:0] unused_lo;
  } t2_word_t;

  function automatic logic [LEN_W-1:0] len_sync(input logic [5:0] f);
    return LEN_W'(f) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] len_porch(input logic [7:0] f);
    return LEN_W'(f) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] len_hact(input logic [5:0] code);
    return LEN_W'({code, 4'b0000}) + LEN_W'(16);
  endfunction

  function automatic logic [LEN_W-1:0] len_vact(input logic [9:0] f);
    return LEN_W'(f) + LEN_W'(1);
  endfunction

endpackage

// File: rtl/lcd_pix_divider.sv
module lcd_pix_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             phase_hi
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] deff;

  assign deff     = (div == '0) ? DIV_W'(1) : div;
  assign tick     = run && (cnt == deff - DIV_W'(1));
  assign phase_hi = (cnt >= (deff >> 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end

  // R2: with a divisor above one, two ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && deff > DIV_W'(1) && $stable(div)) |=> !tick);

endmodule

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [CNT_W-1:0] bp_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] fp_len,
  output logic             wrap,
  output logic             in_sync,
  output logic             in_active
);
  localparam int SUM_W = CNT_W + 2;

  logic [SUM_W-1:0] cnt;
  logic [SUM_W-1:0] act_beg, act_end, last;

  assign act_beg   = SUM_W'(sync_len) + SUM_W'(bp_len);
  assign act_end   = act_beg + SUM_W'(act_len);
  assign last      = act_end + SUM_W'(fp_len) - SUM_W'(1);
  assign wrap      = step && (cnt >= last);
  assign in_sync   = (cnt < SUM_W'(sync_len));
  assign in_active = (cnt >= act_beg) && (cnt < act_end);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (step)    cnt <= cnt + SUM_W'(1);
  end

  // R3: a step that does not wrap advances the position by exactly one
  p_step_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (run && step && !wrap) |=> (cnt == $past(cnt) + SUM_W'(1)));

  // R11: a wrap or a stop brings the counter back to its first phase
  p_wrap_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (wrap || !run) |=> in_sync);

endmodule

// File: rtl/lcd_acbias.sv
module lcd_acbias #(
  parameter int PER_W = 8,
  parameter int NUM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             line_end,
  input  logic [PER_W-1:0] period,
  input  logic [NUM_W-1:0] trans_n,
  output logic             ac_level,
  output logic             ac_irq
);
  logic [PER_W-1:0] line_cnt;
  logic [NUM_W-1:0] tr_cnt;
  logic             flip;

  assign flip = line_end && (line_cnt == period);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      line_cnt <= '0;
      tr_cnt   <= '0;
      ac_level <= 1'b0;
      ac_irq   <= 1'b0;
    end else begin
      ac_irq <= 1'b0;
      if (line_end) begin
        if (flip) begin
          line_cnt <= '0;
          ac_level <= ~ac_level;
          if (trans_n != '0) begin
            if (tr_cnt == trans_n - NUM_W'(1)) begin
              tr_cnt <= '0;
              ac_irq <= 1'b1;
            end else begin
              tr_cnt <= tr_cnt + NUM_W'(1);
            end
          end
        end else begin
          line_cnt <= line_cnt + PER_W'(1);
        end
      end
    end
  end

  // R9: an interrupt strobe always coincides with a level toggle
  p_irq_on_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    ac_irq |-> (ac_level != $past(ac_level)));

  // R8: the level only moves at a line end
  p_toggle_at_line_end_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !line_end) |=> $stable(ac_level));

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_timing_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = LEN_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] ctrl_word,
  input  logic [31:0] raster_word,
  input  logic [31:0] htiming,
  input  logic [31:0] vtiming,
  input  logic [31:0] timing2,
  output logic        pix_clk,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic        pix_req,
  output logic        ac_bias,
  output logic        ac_irq
);
  axis_word_t hw, vw;
  t2_word_t   t2;
  logic       en, tft;
  logic       tick, phase_hi;
  logic       h_wrap, h_sync, h_act;
  logic       v_wrap, v_sync, v_act;
  logic       ac_lvl, ac_pulse;

  assign hw  = axis_word_t'(htiming);
  assign vw  = axis_word_t'(vtiming);
  assign t2  = t2_word_t'(timing2);
  assign en  = raster_word[0];
  assign tft = raster_word[7];

  lcd_pix_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(en),
    .div(ctrl_word[8 +: DIV_W]),
    .tick(tick), .phase_hi(phase_hi)
  );

  lcd_axis_counter #(.CNT_W(CNT_W)) u_hcnt (
    .clk(clk), .rst(rst), .run(en), .step(tick),
    .sync_len(CNT_W'(len_sync(hw.sync))),
    .bp_len(CNT_W'(len_porch(hw.back))),
    .act_len(CNT_W'(len_hact(hw.size[9:4]))),
    .fp_len(CNT_W'(len_porch(hw.front))),
    .wrap(h_wrap), .in_sync(h_sync), .in_active(h_act)
  );

  lcd_axis_counter #(.CNT_W(CNT_W)) u_vcnt (
    .clk(clk), .rst(rst), .run(en), .step(h_wrap),
    .sync_len(CNT_W'(len_sync(vw.sync))),
    .bp_len(CNT_W'(len_porch(vw.back))),
    .act_len(CNT_W'(len_vact(vw.size))),
    .fp_len(CNT_W'(len_porch(vw.front))),
    .wrap(v_wrap), .in_sync(v_sync), .in_active(v_act)
  );

  lcd_acbias #(.PER_W(8), .NUM_W(4)) u_acb (
    .clk(clk), .rst(rst), .run(en && !tft), .line_end(h_wrap),
    .period(t2.acb_period), .trans_n(t2.acb_count),
    .ac_level(ac_lvl), .ac_irq(ac_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pix_clk <= t2.inv_pix;
      hsync   <= t2.inv_line;
      vsync   <= t2.inv_frame;
      de      <= 1'b0;
      pix_req <= 1'b0;
    end else begin
      pix_clk <= phase_hi ^ t2.inv_pix;
      hsync   <= h_sync ^ t2.inv_line;
      vsync   <= v_sync ^ t2.inv_frame;
      de      <= tft && h_act && v_act;
      pix_req <= tick && h_act && v_act;
    end
  end

  assign ac_bias = ac_lvl;
  assign ac_irq  = ac_pulse;

  // R6: data-enable needs active-matrix mode on the previous edge
  p_de_needs_tft_r6: assert property (@(posedge clk) disable iff (rst)
    de |-> $past(tft));

  // R7: every pixel request comes from a pixel-period boundary
  p_req_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> $past(tick));

  // R1: a cleared enable leaves no strobes behind
  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!de && !pix_req && !ac_irq && !ac_bias));

  // R8: active-matrix mode keeps the AC-bias output low
  p_no_acb_in_tft_r8: assert property (@(posedge clk) disable iff (rst)
    tft |=> !ac_bias);

endmodule

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl_word = '0, raster_word = '0, htiming = '0, vtiming = '0, timing2 = '0;
  logic        pix_clk, hsync, vsync, de, pix_req, ac_bias, ac_irq;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_raster_timer dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .raster_word(raster_word),
    .htiming(htiming), .vtiming(vtiming), .timing2(timing2),
    .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_req(pix_req), .ac_bias(ac_bias), .ac_irq(ac_irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag, input bit ip, input bit il, input bit iv);
    chk(tag, "pix_clk idle", int'(pix_clk), int'(ip));
    chk(tag, "hsync idle", int'(hsync), int'(il));
    chk(tag, "vsync idle", int'(vsync), int'(iv));
    chk(tag, "de idle", int'(de), 0);
    chk(tag, "pix_req idle", int'(pix_req), 0);
    chk(tag, "ac_bias idle", int'(ac_bias), 0);
    chk(tag, "ac_irq idle", int'(ac_irq), 0);
  endtask

  // ncyc = 0 runs two full frames
  task automatic run_cfg(input int d, input int hs, input int hb, input int pc, input int hf,
                         input int vs, input int vb, input int vl, input int vf,
                         input bit ip, input bit il, input bit iv, input bit tft,
                         input int ap, input int an, input int ncyc);
    int de_ = (d == 0) ? 1 : d;
    int ht  = hs + 1 + hb + 1 + 16 * (pc + 1) + hf + 1;
    int vt  = vs + 1 + vb + 1 + vl + 1 + vf + 1;
    int hab = hs + 1 + hb + 1;
    int vab = vs + 1 + vb + 1;
    int lim = (ncyc == 0) ? 2 * de_ * ht * vt : ncyc;
    int reqs = 0;
    @(negedge clk);
    ctrl_word   = 32'(d) << 8;
    htiming     = {8'(hb), 8'(hf), 6'(hs), 6'(pc), 4'b0000};
    vtiming     = {8'(vb), 8'(vf), 6'(vs), 10'(vl)};
    timing2     = {6'b0, 2'b0, 1'b0, ip, il, iv, 4'(an), 8'(ap), 8'b0};
    raster_word = {24'b0, tft, 7'b0};
    repeat (2) @(negedge clk);
    chk_idle("R1", ip, il, iv);
    raster_word[0] = 1'b1;
    for (int n = 1; n <= lim; n++) begin
      int q, dv, p, h, v, ln, lc, tg;
      bit hact, vact, e_irq;
      @(posedge clk);
      #1;
      q  = n - 1;
      dv = q % de_;
      p  = q / de_;
      h  = p % ht;
      ln = p / ht;
      v  = ln % vt;
      hact = (h >= hab) && (h < hab + 16 * (pc + 1));
      vact = (v >= vab) && (v < vab + vl + 1);
      lc = n / (de_ * ht);
      tg = lc / (ap + 1);
      e_irq = !tft && an != 0 && (n % (de_ * ht) == 0) && lc > 0 &&
              (lc % (ap + 1) == 0) && (tg % an == 0);
      if (n == 1) begin
        chk("R10", "hsync first edge", int'(hsync), int'(!il));
        chk("R11", "vsync first edge", int'(vsync), int'(!iv));
      end
      chk("R2", "pix_clk", int'(pix_clk), int'((dv >= de_ / 2) ^ ip));
      chk("R3", "hsync", int'(hsync), int'((h < hs + 1) ^ il));
      chk("R5", "vsync", int'(vsync), int'((v < vs + 1) ^ iv));
      chk("R6", "de", int'(de), int'(tft && hact && vact));
      chk("R7", "pix_req", int'(pix_req), int'(hact && vact && dv == de_ - 1));
      chk("R8", "ac_bias", int'(ac_bias), tft ? 0 : (tg % 2));
      chk("R9", "ac_irq", int'(ac_irq), int'(e_irq));
      if (n <= de_ * ht * vt && pix_req) reqs++;
    end
    if (lim >= de_ * ht * vt)
      chk("R4", "requests per frame", reqs, 16 * (pc + 1) * (vl + 1));
    @(negedge clk);
    raster_word[0] = 1'b0;
    @(posedge clk);
    #1;
    chk_idle("R1", ip, il, iv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_idle("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    run_cfg(3, 1, 0, 0, 1, 0, 1, 2, 0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 0);
    run_cfg(1, 0, 1, 0, 0, 1, 0, 1, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1, 3, 0);
    run_cfg(0, 0, 2, 1, 0, 1, 0, 0, 2, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0, 0);
    run_cfg(4, 2, 0, 0, 0, 0, 0, 1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1, 0);
    run_cfg(5, 0, 0, 0, 1, 0, 1, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 2, 2, 0);
    run_cfg(2, 1, 1, 0, 1, 0, 0, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 2, 2, 57);
    run_cfg(2, 1, 1, 0, 1, 0, 0, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 2, 2, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule